// File: doc/BRIEF.md
# Cassette FSK Bit-Stream Modulator

The block turns bytes from a host into a single-bit square wave for a cassette recorder. The line it drives is shared with the audio output. Every bit is sent as exactly two full square-wave cycles. A one uses a short period and a zero uses a period twice as long. Because the wave always has 50% duty, the recording carries no DC bias. The half-period lengths are parameters given in system-clock ticks, so the defaults give 0.3 ms and 0.6 ms halves at the intended clock rate.

The host offers bytes on a valid/ready handshake and flags the final byte of a block with `last_i`. When the block is idle, the first byte it accepts starts a transfer. It first sends a preamble of `SYNC_BYTES` sync frames of value 0xFF, and then sends the data frames. A frame is a start bit of 0, then eight data bits with the least significant bit first, then two stop bits of 1.

A single holding register lets the next byte wait while the current frame is being sent, so frames follow one another with no gap. If the host falls behind, the line rests low until the next byte arrives. When the frame of the last byte ends, the block returns to idle.

Top module: `cas_fsk_mod`

## Requirements
- R1: A bit of value 1 is sent as two periods. Each period is HALF_ONE_TICKS clocks high followed by HALF_ONE_TICKS clocks low, and the high half comes first.
- R2: A bit of value 0 is sent as two periods. Each period is HALF_ZERO_TICKS clocks high followed by HALF_ZERO_TICKS clocks low, and the high half comes first.
- R3: Every frame is 11 bits in this order: a start bit of 0, the eight data bits starting with bit 0, then two stop bits of 1.
- R4: When a byte is accepted while idle, SYNC_BYTES frames of 0xFF go out before that byte's frame. The first sync frame's start bit begins, with wave_o high, in the clock after the accepting edge.
- R5: While idle, and during reset, wave_o is 0, busy_o is 0 and ready_o is 1.
- R6: ready_o is 0 while a byte waits in the holding register. It is also 0 from the acceptance of a byte with last_i = 1 until the block goes idle. Only one byte is taken per cycle in which valid_i and ready_o are both 1.
- R7: If a byte is held when a frame's second stop bit ends, that byte's start bit begins in the very next clock, so there is no idle time between frames.
- R8: If no byte is held when a non-final frame ends, wave_o stays 0 and busy_o stays 1. The next frame starts one clock after a byte is accepted, and no new sync frames are sent.
- R9: After the frame of a byte accepted with last_i = 1 ends, busy_o falls and ready_o rises in the same clock. The next accepted byte starts a new preamble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 8 | Byte offered by the host |
| last_i | input | 1 | Marks the offered byte as the final byte of its block |
| valid_i | input | 1 | Host offers data_i |
| ready_o | output | 1 | Block will take the offered byte at this edge |
| wave_o | output | 1 | Square-wave level for the cassette/audio pin |
| busy_o | output | 1 | A block transfer is in progress |

## Verification
The hardest state to reach is the underrun pause. In it, a frame ends with no byte held and no final byte seen. The stimulus reaches it by accepting a non-final byte and then withholding the next one for longer than the whole preamble and that frame. The same bench also holds valid high across a whole block, which tests acceptance while ready is low and the gap-free hand-over at frame ends. Each block is decoded independently from measured high-phase lengths to check framing, bit order and the count of sync frames. The length of each gap-free block is compared with the sum of its bit times.

// File: rtl/cas_fsk_pkg.sv
package cas_fsk_pkg;
  localparam int unsigned FRAME_BITS = 11;
  localparam logic [7:0]  SYNC_BYTE  = 8'hFF;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_WAIT
  } blk_state_e;
endpackage

// File: rtl/cas_bit_gen.sv
module cas_bit_gen #(
  parameter int unsigned HALF_ONE_TICKS  = 3,
  parameter int unsigned HALF_ZERO_TICKS = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic val_i,
  output logic done_o,
  output logic wave_o
);
  localparam int unsigned HMAX = (HALF_ONE_TICKS > HALF_ZERO_TICKS) ? HALF_ONE_TICKS : HALF_ZERO_TICKS;
  localparam int unsigned TW   = $clog2(HMAX + 1);

  logic [TW-1:0] tick_q, half_len;
  logic [1:0]    half_q;
  logic          val_q, act_q, last_tick;

  assign half_len  = val_q ? TW'(HALF_ONE_TICKS - 1) : TW'(HALF_ZERO_TICKS - 1);
  assign last_tick = act_q && (tick_q == half_len);
  assign done_o    = last_tick && (half_q == 2'd3);
  assign wave_o    = act_q & ~half_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      half_q <= '0;
      val_q  <= 1'b0;
      act_q  <= 1'b0;
    end else if (load_i) begin
      tick_q <= '0;
      half_q <= '0;
      val_q  <= val_i;
      act_q  <= 1'b1;
    end else if (last_tick) begin
      tick_q <= '0;
      half_q <= half_q + 2'd1;
      if (half_q == 2'd3) act_q <= 1'b0;
    end else if (act_q) begin
      tick_q <= tick_q + TW'(1);
    end
  end

  // level holds between half boundaries
  p_half_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && $past(act_q) && !$past(last_tick) && !$past(load_i)) |-> $stable(wave_o));
endmodule

// File: rtl/cas_frame_ser.sv
module cas_frame_ser
  import cas_fsk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  input  logic       bit_done_i,
  output logic       bit_load_o,
  output logic       bit_val_o,
  output logic       frame_done_o
);
  localparam int unsigned CW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-2:0] sh_q;
  logic [CW-1:0]         cnt_q;

  assign bit_load_o   = load_i || (bit_done_i && cnt_q != '0);
  assign bit_val_o    = load_i ? 1'b0 : sh_q[0];
  assign frame_done_o = bit_done_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= {2'b11, byte_i};
      cnt_q <= CW'(FRAME_BITS - 1);
    end else if (bit_done_i && cnt_q != '0) begin
      sh_q  <= {1'b1, sh_q[FRAME_BITS-2:1]};
      cnt_q <= cnt_q - CW'(1);
    end
  end

  p_stop_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_load_o && !load_i && cnt_q <= CW'(2)) |-> bit_val_o);
endmodule

// File: rtl/cas_fsk_mod.sv
module cas_fsk_mod
  import cas_fsk_pkg::*;
#(
  parameter int unsigned HALF_ONE_TICKS  = 3,
  parameter int unsigned HALF_ZERO_TICKS = 6,
  parameter int unsigned SYNC_BYTES      = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] data_i,
  input  logic       last_i,
  input  logic       valid_i,
  output logic       ready_o,
  output logic       wave_o,
  output logic       busy_o
);
  localparam int unsigned SW = $clog2(SYNC_BYTES + 1);

  blk_state_e    st_q;
  logic [7:0]    hold_q;
  logic          full_q, hold_last_q, cur_last_q, last_seen_q;
  logic [SW-1:0] sync_left_q;

  logic       acc, frame_load, frame_done, bit_load, bit_val, bit_done;
  logic [7:0] frame_byte;

  assign acc     = valid_i && ready_o;
  assign ready_o = !full_q && !last_seen_q;
  assign busy_o  = (st_q != ST_IDLE);

  always_comb begin
    frame_load = 1'b0;
    frame_byte = SYNC_BYTE;
    unique case (st_q)
      ST_IDLE: frame_load = acc;
      ST_RUN: if (frame_done) begin
        if (sync_left_q != '0) begin
          frame_load = 1'b1;
        end else if (full_q) begin
          frame_load = 1'b1;
          frame_byte = hold_q;
        end
      end
      ST_WAIT: if (full_q) begin
        frame_load = 1'b1;
        frame_byte = hold_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      hold_q      <= '0;
      full_q      <= 1'b0;
      hold_last_q <= 1'b0;
      cur_last_q  <= 1'b0;
      last_seen_q <= 1'b0;
      sync_left_q <= '0;
    end else begin
      if (acc) begin
        full_q      <= 1'b1;
        hold_q      <= data_i;
        hold_last_q <= last_i;
        if (last_i) last_seen_q <= 1'b1;
      end
      unique case (st_q)
        ST_IDLE: if (acc) begin
          st_q        <= ST_RUN;
          sync_left_q <= SW'(SYNC_BYTES - 1);
        end
        ST_RUN: if (frame_done) begin
          if (sync_left_q != '0) begin
            sync_left_q <= sync_left_q - SW'(1);
          end else if (full_q) begin
            full_q     <= 1'b0;
            cur_last_q <= hold_last_q;
          end else if (cur_last_q) begin
            st_q        <= ST_IDLE;
            cur_last_q  <= 1'b0;
            last_seen_q <= 1'b0;
          end else begin
            st_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (full_q) begin
          full_q     <= 1'b0;
          cur_last_q <= hold_last_q;
          st_q       <= ST_RUN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  cas_frame_ser u_ser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (frame_load),
    .byte_i       (frame_byte),
    .bit_done_i   (bit_done),
    .bit_load_o   (bit_load),
    .bit_val_o    (bit_val),
    .frame_done_o (frame_done)
  );

  cas_bit_gen #(
    .HALF_ONE_TICKS  (HALF_ONE_TICKS),
    .HALF_ZERO_TICKS (HALF_ZERO_TICKS)
  ) u_bit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (bit_load),
    .val_i  (bit_val),
    .done_o (bit_done),
    .wave_o (wave_o)
  );

  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !wave_o);

  p_one_take_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);

  p_no_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && full_q) |=> wave_o);

  p_block_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && frame_done && !full_q && cur_last_q && sync_left_q == '0)
      |=> (!busy_o && ready_o));
endmodule

// File: tb/cas_fsk_mod_bench.sv
module cas_fsk_mod_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H1   = 3;
  localparam int H0   = 6;
  localparam int SYNC = 16;
  localparam int WDOG = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data = '0;
  logic       last = 1'b0;
  logic       valid = 1'b0;
  logic       ready_o, wave_o, busy_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  cas_fsk_mod #(.HALF_ONE_TICKS(H1), .HALF_ZERO_TICKS(H0), .SYNC_BYTES(SYNC)) u_cas_fsk_mod (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .last_i(last), .valid_i(valid),
    .ready_o(ready_o), .wave_o(wave_o), .busy_o(busy_o)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done_flag = 0;

  // ---------------- reference model ----------------
  int bq[$];
  int cur, tick, half, sl, pend_b;
  bit act, blk, wt, curl, lseen, pend_v, pend_l, m_ready, m_acc;

  function automatic int hl(int b);
    return b ? H1 : H0;
  endfunction

  task automatic load_frame(int b);
    bq.delete();
    for (int i = 0; i < 8; i++) bq.push_back((b >> i) & 1);
    bq.push_back(1);
    bq.push_back(1);
    cur = 0; act = 1; tick = 0; half = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bq.delete(); cur = 0; tick = 0; half = 0; sl = 0; pend_b = 0;
      act = 0; blk = 0; wt = 0; curl = 0; lseen = 0; pend_v = 0; pend_l = 0; m_ready = 1;
    end else begin
      m_acc = valid && m_ready;
      if (blk && wt) begin
        if (pend_v) begin
          load_frame(pend_b); curl = pend_l; pend_v = 0; wt = 0;
        end
      end else if (act) begin
        tick++;
        if (tick == hl(cur)) begin
          tick = 0; half++;
          if (half == 4) begin
            if (bq.size() > 0) begin
              cur = bq.pop_front(); half = 0;
            end else begin
              act = 0;
              if (sl > 0) begin load_frame(255); sl--; end
              else if (pend_v) begin load_frame(pend_b); curl = pend_l; pend_v = 0; end
              else if (curl) begin blk = 0; lseen = 0; curl = 0; end
              else wt = 1;
            end
          end
        end
      end
      if (m_acc) begin
        pend_v = 1; pend_b = int'(data); pend_l = last;
        if (last) lseen = 1;
        if (!blk) begin blk = 1; sl = SYNC - 1; load_frame(255); end
      end
      m_ready = !pend_v && !lseen;
    end
  end

  // ---------------- per-cycle compare + decoder ----------------
  int dec_bits[$];
  int hcnt = 0, phase = 0, busy_cyc = 0;
  bit prev_wave = 0, prev_busy = 0;

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      bit ew;
      ew = act && (half % 2 == 0);
      checks++;
      if (wave_o !== ew) begin
        fails++;
        $display("FAIL %s wave cyc=%0d actual=%0b expected=%0b",
                 act ? (cur ? "R1" : "R2") : (blk ? "R8" : "R5"), cyc, wave_o, ew);
      end
      if (ready_o !== m_ready) begin
        fails++;
        $display("FAIL R6 ready cyc=%0d actual=%0b expected=%0b", cyc, ready_o, m_ready);
      end
      if (busy_o !== blk) begin
        fails++;
        $display("FAIL R9 busy cyc=%0d actual=%0b expected=%0b", cyc, busy_o, blk);
      end
      if (busy_o && !prev_busy) begin
        dec_bits.delete(); phase = 0; busy_cyc = 0; hcnt = 0;
      end
      if (busy_o) busy_cyc++;
      if (wave_o) hcnt++;
      else if (prev_wave) begin
        if (phase % 2 == 0) dec_bits.push_back(hcnt == H1 ? 1 : 0);
        phase++; hcnt = 0;
      end
      prev_wave = wave_o;
      prev_busy = busy_o;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done_flag) begin
      done_flag = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  int exp_bytes[$];

  task automatic chk(bit ok, string tag, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  task automatic begin_block();
    exp_bytes.delete();
    for (int i = 0; i < SYNC; i++) exp_bytes.push_back(255);
  endtask

  task automatic send(int b, bit l);
    data = 8'(b); last = l; valid = 1;
    while (!ready_o) @(negedge clk);
    @(negedge clk);
    valid = 0; last = 0;
    exp_bytes.push_back(b);
  endtask

  function automatic int frame_len(int b);
    int s = 4 * H0 + 8 * H1;
    for (int i = 0; i < 8; i++) s += 4 * hl((b >> i) & 1);
    return s;
  endfunction

  task automatic check_block(bit gapfree);
    int nf, got, exp_len;
    while (busy_o) @(negedge clk);
    @(negedge clk);
    chk(ready_o === 1'b1 && busy_o === 1'b0, "R9 idle after last frame", int'(ready_o), 1);
    nf = dec_bits.size() / 11;
    chk(dec_bits.size() == exp_bytes.size() * 11, "R4 decoded bit count", dec_bits.size(), exp_bytes.size() * 11);
    for (int f = 0; f < nf && f < exp_bytes.size(); f++) begin
      got = 0;
      for (int i = 0; i < 8; i++) got |= dec_bits[f*11 + 1 + i] << i;
      chk(dec_bits[f*11] == 0 && dec_bits[f*11+9] == 1 && dec_bits[f*11+10] == 1,
          "R3 start/stop bits", dec_bits[f*11], 0);
      chk(got == exp_bytes[f], f < SYNC ? "R4 sync byte" : "R3 data byte", got, exp_bytes[f]);
    end
    if (gapfree) begin
      exp_len = 0;
      foreach (exp_bytes[i]) exp_len += frame_len(exp_bytes[i]);
      chk(busy_cyc == exp_len, "R7 gap-free block length", busy_cyc, exp_len);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(wave_o === 1'b0 && busy_o === 1'b0 && ready_o === 1'b1, "R5 reset state",
        {29'd0, wave_o, busy_o, ready_o}, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(wave_o === 1'b0 && ready_o === 1'b1, "R5 idle after reset", int'(wave_o), 0);

    // block A: valid held high, gap-free hand-over
    begin_block();
    data = 8'hA5; last = 0; valid = 1;
    @(negedge clk);
    chk(wave_o === 1'b1 && busy_o === 1'b1, "R4 preamble starts next clock", int'(wave_o), 1);
    chk(ready_o === 1'b0, "R6 ready low while byte held", int'(ready_o), 0);
    valid = 0;
    exp_bytes.push_back(8'hA5);
    send(8'h00, 0);
    send(8'h3C, 1);
    chk(ready_o === 1'b0, "R6 ready low after last byte", int'(ready_o), 0);
    check_block(1);

    // block B: host underrun between bytes
    begin_block();
    send(8'h81, 0);
    repeat (4000) @(negedge clk);
    chk(busy_o === 1'b1 && wave_o === 1'b0, "R8 line low during underrun", int'(wave_o), 0);
    chk(ready_o === 1'b1, "R8 ready during underrun", int'(ready_o), 1);
    exp_bytes.push_back(8'h7E);
    data = 8'h7E; last = 1; valid = 1;
    @(negedge clk);
    valid = 0; last = 0;
    chk(wave_o === 1'b0, "R8 frame waits one clock", int'(wave_o), 0);
    @(negedge clk);
    chk(wave_o === 1'b1, "R8 frame starts after acceptance", int'(wave_o), 1);
    check_block(0);

    // block C: single final byte, fresh preamble
    begin_block();
    send(8'h00, 1);
    check_block(1);

    repeat (5) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule